// File: doc/BRIEF.md
# Scalar Instruction Decoder with Integer Execute

This block sits at the front of a scalar microcode engine. Each cycle it may accept one 32-bit instruction word, classify it, and execute it if it is an integer register-register or register-immediate operation. The operand indices come straight from the instruction word and go to an external 32-entry register file. That file returns the two operand values in the same cycle. One cycle later the block presents a registered write-back: destination index, value and a one-cycle enable.

Words whose top seven bits equal 0x25 belong to a separate vector unit. The block does not execute them. It raises a one-cycle dispatch strobe and hands over the decoded field bundle. Every other encoding outside the supported integer set raises a one-cycle reserved flag and has no other effect. No instruction can trap: additions and subtractions wrap.

Control is a small state machine whose state is the outcome of the previous cycle's instruction:
- `ST_IDLE`: no instruction was accepted.
- `ST_WRITE`: an integer result is being written.
- `ST_DISCARD`: an integer result was aimed at register 0 and is dropped.
- `ST_DISPATCH`: a vector operation is being handed over.
- `ST_RESERVED`: an unsupported encoding was seen.

At each clock edge, an edge with `in_valid` low moves to `ST_IDLE`. An edge with `in_valid` high moves to the state chosen by decoding the present word. This holds from every state, so back-to-back instructions chain with no bubble. Reset forces `ST_IDLE`.

Top module: `sdu_core`

## Requirements
- R1: A word with bits 31:25 equal to 0x25 gives a one-cycle `vec_go` in the cycle after it is accepted. The handed-over fields are: function = bits 5:0, vd = bits 10:6, vs = bits 15:11, vt = bits 20:16, element = bits 24:21. No register write occurs.
- R2: Register index 0 reads as zero whatever `rs_data`/`rt_data` carry. An integer result destined for index 0 produces no write, no dispatch and no reserved flag.
- R3: SPECIAL function codes 0x20/0x21 add and 0x22/0x23 subtract (rs minus rt). Both wrap modulo 2^32 and have no overflow effect. SPECIAL is opcode (bits 31:26) 0.
- R4: The shifts are SLL 0x00, SRL 0x02, SRA 0x03, SLLV 0x04, SRLV 0x06 and SRAV 0x07. Each shifts rt. The amount is bits 10:6 for the immediate forms and the low 5 bits of rs for the variable forms. SRA and SRAV replicate the sign bit.
- R5: Opcodes 0x0C (AND), 0x0D (OR) and 0x0E (XOR) zero-extend the 16-bit immediate. Opcodes 0x08/0x09 (add) and 0x0A (signed less-than) sign-extend it. Immediate forms write register rt (bits 20:16); register forms write rd (bits 15:11).
- R6: Opcode 0x0B compares rs unsigned against the zero-extended immediate.
- R7: Opcode 0x0F writes the immediate into bits 31:16 and zero into bits 15:0.
- R8: Any other opcode, any other SPECIAL function code, and opcode 0x12 with bit 25 clear are reserved. They give a one-cycle `rsvd_flag` and no write or dispatch.
- R9: SLT (0x2A) compares signed and SLTU (0x2B) compares unsigned. Both write exactly 0 or 1.
- R10: Results appear, registered, exactly one cycle after `in_valid`. Each strobe lasts one cycle, and a cycle with `in_valid` low gives no strobe in the next cycle.
- R11: During and right after reset, `wb_en`, `vec_go` and `rsvd_flag` are low.
- R12: SPECIAL function codes 0x24, 0x25, 0x26 and 0x27 compute rs AND, OR, XOR and NOR rt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| rs_idx | output | 5 | First operand index for the register file |
| rt_idx | output | 5 | Second operand index for the register file |
| rs_data | input | 32 | Register file value at `rs_idx` |
| rt_data | input | 32 | Register file value at `rt_idx` |
| wb_en | output | 1 | Write-back enable (one cycle) |
| wb_idx | output | 5 | Write-back register index |
| wb_val | output | 32 | Write-back value |
| vec_go | output | 1 | Vector dispatch strobe (one cycle) |
| vec_func | output | 6 | Vector function field |
| vec_vd | output | 5 | Vector destination field |
| vec_vs | output | 5 | Vector first source field |
| vec_vt | output | 5 | Vector second source field |
| vec_elem | output | 4 | Vector element selector |
| rsvd_flag | output | 1 | Reserved encoding seen (one cycle) |

## Verification
Because every state is left on the next edge, an integer write-back and the decode of a following vector word occupy adjacent cycles. The dispatch strobe and a write can then sit one edge apart on the same registered outputs. The bench issues an add immediately followed by a vector word, with no idle cycle between them. It checks that the write shows only in the first cycle and the dispatch only in the second, each carrying its own instruction's data. A final idle cycle must leave all strobes low. A checker also requires that at most one of the three strobes is high in any cycle.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;
    localparam int SHAMT_W  = 5;
    localparam int ELEM_W   = 4;
    localparam logic [6:0] VEC_TAG = 7'h25;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
    } alu_op_e;

    typedef enum logic [1:0] {
        CL_INT, CL_VEC, CL_RSVD
    } cls_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WRITE, ST_DISCARD, ST_DISPATCH, ST_RESERVED
    } st_e;

    typedef struct packed {
        logic [OPC_W-1:0]  func;
        logic [RIDX_W-1:0] vd;
        logic [RIDX_W-1:0] vs;
        logic [RIDX_W-1:0] vt;
        logic [ELEM_W-1:0] elem;
    } vec_bundle_t;
endpackage

// File: rtl/sdu_decode.sv
module sdu_decode
    import sdu_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output cls_e              cls,
    output alu_op_e           alu_op,
    output logic              use_imm,
    output logic              var_shift,
    output logic [XLEN-1:0]   imm_ext,
    output logic [RIDX_W-1:0] dest,
    output vec_bundle_t       vec
);
    logic [OPC_W-1:0] opc;
    logic [OPC_W-1:0] fn;
    logic [IMM_W-1:0] imm;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];
    assign imm = instr[IMM_W-1:0];

    assign vec.func = instr[5:0];
    assign vec.vd   = instr[10:6];
    assign vec.vs   = instr[15:11];
    assign vec.vt   = instr[20:16];
    assign vec.elem = instr[24:21];

    always_comb begin
        cls       = CL_RSVD;
        alu_op    = ALU_ADD;
        use_imm   = 1'b1;
        var_shift = 1'b0;
        imm_ext   = {{(XLEN-IMM_W){1'b0}}, imm};
        dest      = instr[20:16];
        if (instr[31:25] == VEC_TAG) begin
            cls = CL_VEC;
        end else if (opc == 6'h00) begin
            use_imm = 1'b0;
            dest    = instr[15:11];
            cls     = CL_INT;
            unique case (fn)
                6'h00: alu_op = ALU_SLL;
                6'h02: alu_op = ALU_SRL;
                6'h03: alu_op = ALU_SRA;
                6'h04: begin alu_op = ALU_SLL; var_shift = 1'b1; end
                6'h06: begin alu_op = ALU_SRL; var_shift = 1'b1; end
                6'h07: begin alu_op = ALU_SRA; var_shift = 1'b1; end
                6'h20, 6'h21: alu_op = ALU_ADD;
                6'h22, 6'h23: alu_op = ALU_SUB;
                6'h24: alu_op = ALU_AND;
                6'h25: alu_op = ALU_OR;
                6'h26: alu_op = ALU_XOR;
                6'h27: alu_op = ALU_NOR;
                6'h2A: alu_op = ALU_SLT;
                6'h2B: alu_op = ALU_SLTU;
                default: cls = CL_RSVD;
            endcase
        end else begin
            cls = CL_INT;
            unique case (opc)
                6'h08, 6'h09: begin
                    alu_op  = ALU_ADD;
                    imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
                end
                6'h0A: begin
                    alu_op  = ALU_SLT;
                    imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
                end
                6'h0B: alu_op = ALU_SLTU;
                6'h0C: alu_op = ALU_AND;
                6'h0D: alu_op = ALU_OR;
                6'h0E: alu_op = ALU_XOR;
                6'h0F: alu_op = ALU_LUI;
                default: cls = CL_RSVD;
            endcase
        end
    end
endmodule

// File: rtl/sdu_alu.sv
module sdu_alu
    import sdu_pkg::*;
(
    input  alu_op_e            op,
    input  logic [XLEN-1:0]    a,
    input  logic [XLEN-1:0]    b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [XLEN-1:0]    y
);
    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_NOR:  y = ~(a | b);
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
            ALU_SLL:  y = b << shamt;
            ALU_SRL:  y = b >> shamt;
            ALU_SRA:  y = $unsigned($signed(b) >>> shamt);
            ALU_LUI:  y = {b[IMM_W-1:0], {IMM_W{1'b0}}};
            default:  y = '0;
        endcase
    end
endmodule

// File: rtl/sdu_core.sv
module sdu_core
    import sdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    output logic [4:0]        rs_idx,
    output logic [4:0]        rt_idx,
    input  logic [31:0]       rs_data,
    input  logic [31:0]       rt_data,
    output logic              wb_en,
    output logic [4:0]        wb_idx,
    output logic [31:0]       wb_val,
    output logic              vec_go,
    output logic [5:0]        vec_func,
    output logic [4:0]        vec_vd,
    output logic [4:0]        vec_vs,
    output logic [4:0]        vec_vt,
    output logic [3:0]        vec_elem,
    output logic              rsvd_flag
);
    cls_e               cls;
    alu_op_e            alu_op;
    logic               use_imm;
    logic               var_shift;
    logic [XLEN-1:0]    imm_ext;
    logic [RIDX_W-1:0]  dest;
    vec_bundle_t        vec_d;
    logic [XLEN-1:0]    opa;
    logic [XLEN-1:0]    opb_reg;
    logic [XLEN-1:0]    opb;
    logic [SHAMT_W-1:0] shamt;
    logic [XLEN-1:0]    alu_y;

    st_e                state_q;
    st_e                state_d;
    logic [XLEN-1:0]    res_q;
    logic [RIDX_W-1:0]  dest_q;
    vec_bundle_t        vec_q;

    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];

    sdu_decode u_dec (
        .instr     (instr),
        .cls       (cls),
        .alu_op    (alu_op),
        .use_imm   (use_imm),
        .var_shift (var_shift),
        .imm_ext   (imm_ext),
        .dest      (dest),
        .vec       (vec_d)
    );

    // index 0 is hard-wired to zero regardless of the file's answer
    assign opa     = (rs_idx == '0) ? '0 : rs_data;
    assign opb_reg = (rt_idx == '0) ? '0 : rt_data;
    assign opb     = use_imm ? imm_ext : opb_reg;
    assign shamt   = var_shift ? opa[SHAMT_W-1:0] : instr[10:6];

    sdu_alu u_alu (
        .op    (alu_op),
        .a     (opa),
        .b     (opb),
        .shamt (shamt),
        .y     (alu_y)
    );

    always_comb begin
        state_d = ST_IDLE;
        if (in_valid) begin
            unique case (cls)
                CL_VEC:  state_d = ST_DISPATCH;
                CL_RSVD: state_d = ST_RESERVED;
                CL_INT:  state_d = (dest == '0) ? ST_DISCARD : ST_WRITE;
                default: state_d = ST_RESERVED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            dest_q <= '0;
            vec_q  <= '0;
        end else if (in_valid) begin
            res_q  <= alu_y;
            dest_q <= dest;
            vec_q  <= vec_d;
        end
    end

    always_comb begin
        wb_en     = 1'b0;
        vec_go    = 1'b0;
        rsvd_flag = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_WRITE:    wb_en = 1'b1;
            ST_DISCARD:  ;
            ST_DISPATCH: vec_go = 1'b1;
            ST_RESERVED: rsvd_flag = 1'b1;
            default:     ;
        endcase
    end

    assign wb_idx   = dest_q;
    assign wb_val   = res_q;
    assign vec_func = vec_q.func;
    assign vec_vd   = vec_q.vd;
    assign vec_vs   = vec_q.vs;
    assign vec_vt   = vec_q.vt;
    assign vec_elem = vec_q.elem;
endmodule

// File: rtl/sdu_chk.sv
module sdu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic        wb_en,
    input logic [4:0]  wb_idx,
    input logic [31:0] wb_val,
    input logic        vec_go,
    input logic [5:0]  vec_func,
    input logic [4:0]  vec_vd,
    input logic [4:0]  vec_vs,
    input logic [4:0]  vec_vt,
    input logic [3:0]  vec_elem,
    input logic        rsvd_flag
);
    p_vec_detect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && instr[31:25] == 7'h25 |=> vec_go);

    p_vec_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
        vec_go |-> {vec_func, vec_vd, vec_vs, vec_vt, vec_elem} ==
                   $past({instr[5:0], instr[10:6], instr[15:11], instr[20:16], instr[24:21]}));

    p_no_zero_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> wb_idx != 5'd0);

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, vec_go, rsvd_flag}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(wb_en || vec_go || rsvd_flag));

    p_upper_imm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && $past(in_valid) && $past(instr[31:26]) == 6'h0F |-> wb_val[15:0] == 16'h0);

    p_bool_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en && $past(in_valid) && $past(instr[31:26]) == 6'h00 &&
        ($past(instr[5:0]) == 6'h2A || $past(instr[5:0]) == 6'h2B) |-> wb_val[31:1] == 31'd0);
endmodule

bind sdu_core sdu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .wb_en     (wb_en),
    .wb_idx    (wb_idx),
    .wb_val    (wb_val),
    .vec_go    (vec_go),
    .vec_func  (vec_func),
    .vec_vd    (vec_vd),
    .vec_vs    (vec_vs),
    .vec_vt    (vec_vt),
    .vec_elem  (vec_elem),
    .rsvd_flag (rsvd_flag)
);

// File: tb/tb_sdu_core.sv
module tb_sdu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  rs_idx, rt_idx;
    logic [31:0] rs_data = '0;
    logic [31:0] rt_data = '0;
    logic        wb_en, vec_go, rsvd_flag;
    logic [4:0]  wb_idx, vec_vd, vec_vs, vec_vt;
    logic [31:0] wb_val;
    logic [5:0]  vec_func;
    logic [3:0]  vec_elem;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sdu_core dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .rs_data(rs_data), .rt_data(rt_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
        .vec_go(vec_go), .vec_func(vec_func), .vec_vd(vec_vd), .vec_vs(vec_vs),
        .vec_vt(vec_vt), .vec_elem(vec_elem), .rsvd_flag(rsvd_flag)
    );

    function automatic logic [31:0] enc_r(logic [4:0] s, logic [4:0] t, logic [4:0] d,
                                          logic [4:0] sa, logic [5:0] fn);
        return {6'h00, s, t, d, sa, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] s, logic [4:0] t,
                                          logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    // kinds: 0 dropped, 1 write, 2 vector dispatch, 3 reserved
    localparam int N = 29;
    localparam logic [31:0] V_INS [N] = '{
        enc_r(1, 2, 3, 0, 6'h21),   // R3 wrap add
        enc_r(1, 2, 4, 0, 6'h22),   // R3 sub borrow
        enc_r(1, 2, 5, 0, 6'h20),   // R3 no trap
        enc_r(0, 2, 6, 4, 6'h00),   // R4 sll
        enc_r(0, 2, 7, 4, 6'h03),   // R4 sra
        enc_r(0, 2, 8, 4, 6'h02),   // R4 srl
        enc_r(1, 2, 9, 0, 6'h06),   // R4 srlv low 5 bits
        enc_r(1, 2, 10, 0, 6'h07),  // R4 srav
        enc_r(1, 2, 11, 0, 6'h04),  // R4 sllv by 31
        enc_r(1, 2, 12, 0, 6'h27),  // R12 nor
        enc_r(1, 2, 13, 0, 6'h26),  // R12 xor
        enc_r(1, 2, 14, 0, 6'h24),  // R12 and
        enc_r(1, 2, 15, 0, 6'h25),  // R12 or
        enc_r(1, 2, 16, 0, 6'h2A),  // R9 slt signed
        enc_r(1, 2, 17, 0, 6'h2B),  // R9 sltu unsigned
        enc_i(6'h08, 1, 18, 16'hFFFF), // R5 addi sign-extend
        enc_i(6'h0D, 1, 19, 16'h8001), // R5 ori zero-extend
        enc_i(6'h0C, 1, 20, 16'hF0F0), // R5 andi
        enc_i(6'h0A, 1, 21, 16'hFFFF), // R5 slti signed
        enc_i(6'h0B, 1, 22, 16'h8000), // R6 sltiu zero-extended, false
        enc_i(6'h0F, 1, 23, 16'hABCD), // R7 lui
        enc_i(6'h0E, 1, 24, 16'h8001), // R5 xori
        {7'h25, 4'hA, 5'd3, 5'd7, 5'd9, 6'h13}, // R1 vector
        enc_i(6'h23, 1, 2, 16'h0000),  // R8 load opcode reserved
        enc_r(1, 2, 3, 0, 6'h01),      // R8 reserved function
        enc_i(6'h12, 0, 0, 16'h0000),  // R8 opcode 0x12, bit 25 clear
        enc_r(1, 2, 0, 0, 6'h21),      // R2 write to index 0 dropped
        enc_r(0, 2, 25, 0, 6'h20),     // R2 index 0 reads zero
        enc_i(6'h0B, 1, 26, 16'h8000)  // R6 sltiu true
    };
    localparam logic [31:0] V_RS [N] = '{
        32'hFFFFFFFF, 32'h00000001, 32'h7FFFFFFF, 32'h0, 32'h0, 32'h0,
        32'h00000024, 32'hFFFFFFE1, 32'h0000003F, 32'h0F0F0000, 32'hFF00FF00,
        32'hFF00FF00, 32'hFF00FF00, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000010,
        32'h00010000, 32'hFFFF1234, 32'hFFFFFFF0, 32'h00010000, 32'hDEADBEEF,
        32'h0000FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'h11111111, 32'h12345678,
        32'h00007FFF
    };
    localparam logic [31:0] V_RT [N] = '{
        32'h00000002, 32'h00000002, 32'h00000001, 32'h80000001, 32'h80000000,
        32'h80000000, 32'h80000000, 32'h80000000, 32'h00000001, 32'h00F0000F,
        32'h0FF00FF0, 32'h0FF00FF0, 32'h0FF00FF0, 32'h00000001, 32'h00000001,
        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
        32'h0, 32'h22222222, 32'h00000005, 32'h0
    };
    localparam logic [1:0] V_KIND [N] = '{
        2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1,
        2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd3,
        2'd3, 2'd3, 2'd0, 2'd1, 2'd1
    };
    localparam logic [31:0] V_EXP [N] = '{
        32'h00000001, 32'hFFFFFFFF, 32'h80000000, 32'h00000010, 32'hF8000000,
        32'h08000000, 32'h08000000, 32'hC0000000, 32'h80000000, 32'hF000FFF0,
        32'hF0F0F0F0, 32'h0F000F00, 32'hFFF0FFF0, 32'h00000001, 32'h00000000,
        32'h0000000F, 32'h00018001, 32'h00001030, 32'h00000001, 32'h00000000,
        32'hABCD0000, 32'h00007FFE, {7'd0, 6'h13, 5'd9, 5'd7, 5'd3, 4'hA},
        32'h0, 32'h0, 32'h0, 32'h0, 32'h00000005, 32'h00000001
    };
    localparam int V_REQ [N] = '{
        3, 3, 3, 4, 4, 4, 4, 4, 4, 12, 12, 12, 12, 9, 9, 5, 5, 5, 5, 6, 7, 5,
        1, 8, 8, 8, 2, 2, 6
    };

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic strobes(string req, bit we, bit vg, bit rf);
        chk({wb_en, vec_go, rsvd_flag} == {we, vg, rf}, req, "strobes {wb,vec,rsvd}",
            {29'd0, wb_en, vec_go, rsvd_flag}, {29'd0, we, vg, rf});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        strobes("R11", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        strobes("R11", 0, 0, 0);

        // table walk
        for (int i = 0; i < N; i++) begin
            string tag;
            tag = $sformatf("R%0d[%0d]", V_REQ[i], i);
            @(negedge clk);
            in_valid = 1'b1;
            instr    = V_INS[i];
            rs_data  = V_RS[i];
            rt_data  = V_RT[i];
            @(negedge clk);
            in_valid = 1'b0;
            strobes(tag, V_KIND[i] == 2'd1, V_KIND[i] == 2'd2, V_KIND[i] == 2'd3);
            if (V_KIND[i] == 2'd1) begin
                chk(wb_idx == (V_INS[i][31:26] == 6'h00 ? V_INS[i][15:11] : V_INS[i][20:16]),
                    tag, "wb_idx", {27'd0, wb_idx},
                    {27'd0, (V_INS[i][31:26] == 6'h00 ? V_INS[i][15:11] : V_INS[i][20:16])});
                chk(wb_val == V_EXP[i], tag, "wb_val", wb_val, V_EXP[i]);
            end
            if (V_KIND[i] == 2'd2)
                chk({7'd0, vec_func, vec_vd, vec_vs, vec_vt, vec_elem} == V_EXP[i], tag,
                    "vector fields", {7'd0, vec_func, vec_vd, vec_vs, vec_vt, vec_elem}, V_EXP[i]);
        end

        // R10: idle cycle gives no strobe
        @(negedge clk);
        strobes("R10 idle", 0, 0, 0);

        // R10 / R1: back-to-back write then dispatch
        in_valid = 1'b1;
        instr    = enc_r(1, 2, 3, 0, 6'h21);
        rs_data  = 32'h00000010;
        rt_data  = 32'h00000020;
        @(negedge clk);
        strobes("R10 b2b first", 1, 0, 0);
        chk(wb_val == 32'h30, "R3 b2b", "wb_val", wb_val, 32'h30);
        instr = {7'h25, 4'h5, 5'd1, 5'd2, 5'd4, 6'h2C};
        @(negedge clk);
        strobes("R1 b2b second", 0, 1, 0);
        chk({vec_func, vec_vd, vec_vs, vec_vt, vec_elem} == {6'h2C, 5'd4, 5'd2, 5'd1, 4'h5},
            "R1 b2b", "vector fields", {7'd0, vec_func, vec_vd, vec_vs, vec_vt, vec_elem},
            {7'd0, 6'h2C, 5'd4, 5'd2, 5'd1, 4'h5});
        in_valid = 1'b0;
        @(negedge clk);
        strobes("R10 after b2b", 0, 0, 0);

        // R11: reset while an instruction is offered
        in_valid = 1'b1;
        instr    = enc_r(1, 2, 3, 0, 6'h21);
        rst_n    = 1'b0;
        @(negedge clk);
        strobes("R11 busy reset", 0, 0, 0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        strobes("R11 after reset", 0, 0, 0);

        finish_run();
    end
endmodule